// File: doc/BRIEF.md
# Fixed Off-Time Chopping Controller

This block is the digital side of one current-regulated H-bridge channel. While the bridge is conducting, a comparator flag reports that the winding current has reached its trip level. The controller then stops driving and holds the bridge in recirculation for a programmed off-time. An external chop request starts the same off period. The off period can begin with a fast-decay phase and continue in slow decay. Its length is counted in ticks of a prescaled clock, and each tick is `PRESCALE` system clocks.

During the off period the controller removes the enable from one side of the bridge. Which side depends on the rectification mode. After a crossover delay of two ticks it turns on synchronous rectification. Rectification stays on for the rest of the period unless the mode's own stop condition fires: the zero-current flag in active mode, or the reverse-current-limit flag in passive mode. When the period ends, both sides are enabled again and a blanking window masks the trip flag. A fault flag disables every output. An undervoltage or sleep condition also disables every output and clears the configuration register.

Top module: `offtime_chopper`

## Requirements
- R1: After reset, with no fault, undervoltage or sleep input, `src_en_o` and `snk_en_o` are 1, and `rect_en_o`, `fast_o` and `off_o` are 0.
- R2: A trip that is sampled on a clock edge while the bridge is conducting and not blanked raises `off_o` after that edge. `off_o` then stays high for exactly (off field + 1) × `PRESCALE` clocks. Trip and chop inputs have no effect while `off_o` is high.
- R3: A chop request sampled while the bridge is conducting starts an off period in the same way. Blanking does not mask a chop request.
- R4: During an off period in low-side mode, `src_en_o`=1 and `snk_en_o`=0. In every other mode, `src_en_o`=0 and `snk_en_o`=1. While the bridge is conducting, both are 1.
- R5: With the decay bit set to mixed, `fast_o` is high for the first min(fast field, off field + 1) × `PRESCALE` clocks of the off period. If the fast field is longer than the off time, the whole period is fast decay. With the bit set to slow-only, `fast_o` stays 0.
- R6: `rect_en_o` rises 2 × `PRESCALE` clocks after the off period starts, which is the crossover delay. It stays high until the period ends unless it is stopped. In disabled mode it never rises.
- R7: In active mode, a zero-current flag sampled during the off period turns `rect_en_o` off from the next clock to the end of the period. In passive mode the zero-current flag has no effect.
- R8: In passive mode, a reverse-limit flag sampled during the off period turns `rect_en_o` off from the next clock to the end of the period. In active mode the reverse-limit flag has no effect.
- R9: After an off period ends, a trip is ignored for `BLANK_TICKS` × `PRESCALE` clocks. A trip that is held through the window starts the next off period 2 × `PRESCALE` + 1 clocks after the first conducting clock.
- R10: While `fault_i` is 1, all five outputs are 0 in the same cycle. The configuration is kept.
- R11: While `uvlo_i` or `sleep_i` is 1, all five outputs are 0 in the same cycle. The configuration register is cleared to zero, and writes to it are ignored.
- R12: The configuration word `cfg_wdata_i` is loaded on a clock edge where `cfg_we_i` is 1. Its fields are:
  - bits [11:7]: off field
  - bits [6:3]: fast field
  - bit [2]: decay select, 1 for mixed and 0 for slow-only
  - bits [1:0]: rectification mode, 0 disabled, 1 active, 2 passive, 3 low-side

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 12 | Configuration word |
| trip_i | input | 1 | Current-trip comparator flag |
| chop_i | input | 1 | External chop request |
| zero_i | input | 1 | Zero-current flag |
| rev_lim_i | input | 1 | Reverse-current-limit flag |
| fault_i | input | 1 | Over-temperature or low-supply fault |
| uvlo_i | input | 1 | Undervoltage condition |
| sleep_i | input | 1 | Sleep request |
| src_en_o | output | 1 | Source-side switch enable |
| snk_en_o | output | 1 | Sink-side switch enable |
| rect_en_o | output | 1 | Synchronous rectification enable |
| fast_o | output | 1 | Fast-decay phase indicator |
| off_o | output | 1 | Off period in progress |

## Verification
The bench targets four kinds of corner case:
- **Fast field longer than the off time.** A design that compares against the wrong bound would end fast decay early, or leave `fast_o` high after the period ends.
- **A stop flag in the wrong mode.** The zero-current and reverse-limit flags are each applied in the mode where they must be ignored. A swapped mode decode would cut rectification early.
- **Inputs held high across the end of a period.** A held trip tests the blanking gap, and a held chop tests the immediate restart. A design that blanked chops, or lost the blanking count, would restart on the wrong clock.
- **Configuration across disable conditions.** Writes are attempted during undervoltage and sleep, and a fault is applied in the middle of a period. A design that kept the configuration through undervoltage or sleep, or cleared it on a fault, would produce an off period of the wrong length afterwards.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
  localparam int OFF_W = 5;
  localparam int FAST_W = 4;
  localparam int CFG_W = OFF_W + FAST_W + 3;
  localparam int EL_W = OFF_W + 1;

  typedef enum logic [1:0] {
    SR_NONE    = 2'd0,
    SR_ACTIVE  = 2'd1,
    SR_PASSIVE = 2'd2,
    SR_LOWSIDE = 2'd3
  } sr_mode_e;

  typedef struct packed {
    logic [OFF_W-1:0]  off_len;
    logic [FAST_W-1:0] fast_len;
    logic              mixed;
    sr_mode_e          sr;
  } chop_cfg_t;

  // Fast decay holds while fewer than fast_len ticks have elapsed (mixed only).
  function automatic logic in_fast(input logic [EL_W-1:0] el, input chop_cfg_t c);
    return c.mixed && (el < EL_W'(c.fast_len));
  endfunction

  // The tick ending the period is the one seen when off_len ticks have elapsed.
  function automatic logic off_last(input logic [EL_W-1:0] el, input chop_cfg_t c);
    return el == EL_W'(c.off_len);
  endfunction

  // Mode-specific stop condition for rectification.
  function automatic logic rect_cut(input sr_mode_e m, input logic zero, input logic rev);
    return ((m == SR_ACTIVE) && zero) || ((m == SR_PASSIVE) && rev);
  endfunction
endpackage

// File: rtl/chop_tick.sv
`timescale 1ns/1ps
module chop_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chop_seq.sv
`timescale 1ns/1ps
module chop_seq
  import chop_pkg::*;
#(
  parameter int BLANK_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic            tick,
  input  logic            trip,
  input  logic            chop,
  input  chop_cfg_t       cfg,
  output logic            off_q,
  output logic [EL_W-1:0] elapsed,
  output logic            blank,
  output logic            start,
  output logic            finish
);
  localparam int BW = (BLANK_TICKS > 0) ? $clog2(BLANK_TICKS + 1) : 1;
  logic [BW-1:0] blank_cnt;

  assign blank  = (blank_cnt != '0);
  // R2 R3: trip is masked by blanking, chop is not
  assign start  = !off_q && !halt && (chop || (trip && !blank));
  assign finish = off_q && tick && off_last(elapsed, cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= 1'b0;
      elapsed   <= '0;
      blank_cnt <= '0;
    end else if (halt) begin
      off_q     <= 1'b0;
      elapsed   <= '0;
      blank_cnt <= '0;
    end else if (start) begin
      off_q   <= 1'b1;
      elapsed <= '0;
    end else if (finish) begin
      off_q     <= 1'b0;
      elapsed   <= '0;
      blank_cnt <= BW'(BLANK_TICKS); // R9
    end else if (tick) begin
      if (off_q)      elapsed   <= elapsed + 1'b1;
      else if (blank) blank_cnt <= blank_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/chop_rect.sv
`timescale 1ns/1ps
module chop_rect
  import chop_pkg::*;
#(
  parameter int XOVER_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic            start,
  input  logic            off_q,
  input  logic [EL_W-1:0] elapsed,
  input  sr_mode_e        sr,
  input  logic            zero,
  input  logic            rev,
  output logic            rect_ok
);
  logic kill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               kill_q <= 1'b0;
    else if (halt || start)                   kill_q <= 1'b0;
    else if (off_q && rect_cut(sr, zero, rev)) kill_q <= 1'b1; // R7 R8
  end

  // R6: crossover delay before the rectifier is allowed on
  assign rect_ok = off_q && (sr != SR_NONE) && (elapsed >= EL_W'(XOVER_TICKS)) && !kill_q;
endmodule

// File: rtl/offtime_chopper.sv
`timescale 1ns/1ps
module offtime_chopper
  import chop_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int BLANK_TICKS = 2,
  parameter int XOVER_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             trip_i,
  input  logic             chop_i,
  input  logic             zero_i,
  input  logic             rev_lim_i,
  input  logic             fault_i,
  input  logic             uvlo_i,
  input  logic             sleep_i,
  output logic             src_en_o,
  output logic             snk_en_o,
  output logic             rect_en_o,
  output logic             fast_o,
  output logic             off_o
);
  chop_cfg_t       cfg_q;
  logic            wipe_w, dis_w, tick_w, off_q, blank_w, start_w, finish_w, rect_w;
  logic [EL_W-1:0] elapsed_w;
  logic            low_side_w;

  assign wipe_w = uvlo_i || sleep_i;
  assign dis_w  = wipe_w || fault_i;

  // R11 R12: configuration register, cleared while undervoltage or sleep
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (wipe_w)   cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= chop_cfg_t'(cfg_wdata_i);
  end

  chop_tick #(.DIV(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(start_w || finish_w || dis_w), .tick(tick_w)
  );

  chop_seq #(.BLANK_TICKS(BLANK_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .halt(dis_w), .tick(tick_w), .trip(trip_i),
    .chop(chop_i), .cfg(cfg_q), .off_q(off_q), .elapsed(elapsed_w),
    .blank(blank_w), .start(start_w), .finish(finish_w)
  );

  chop_rect #(.XOVER_TICKS(XOVER_TICKS)) u_rect (
    .clk(clk), .rst_n(rst_n), .halt(dis_w), .start(start_w), .off_q(off_q),
    .elapsed(elapsed_w), .sr(cfg_q.sr), .zero(zero_i), .rev(rev_lim_i),
    .rect_ok(rect_w)
  );

  assign low_side_w = (cfg_q.sr == SR_LOWSIDE);

  // R4 R10 R11: side selection and output gating
  assign src_en_o  = !dis_w && (!off_q || low_side_w);
  assign snk_en_o  = !dis_w && (!off_q || !low_side_w);
  assign rect_en_o = !dis_w && rect_w;
  assign fast_o    = !dis_w && off_q && in_fast(elapsed_w, cfg_q); // R5
  assign off_o     = !dis_w && off_q;
endmodule

// File: rtl/chop_chk.sv
`timescale 1ns/1ps
module chop_chk
  import chop_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      trip_i,
  input logic      chop_i,
  input logic      zero_i,
  input logic      rev_lim_i,
  input logic      uvlo_i,
  input logic      sleep_i,
  input logic      src_en_o,
  input logic      snk_en_o,
  input logic      rect_en_o,
  input logic      fast_o,
  input logic      off_o,
  input logic      dis_w,
  input logic      blank_w,
  input chop_cfg_t cfg_q
);
  AST_TRIP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_o && !dis_w && !blank_w && trip_i) |=> (off_o || dis_w)); // R2
  AST_CHOP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_o && !dis_w && chop_i) |=> (off_o || dis_w)); // R3
  AST_BLANK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_o && !dis_w && blank_w && !chop_i) |=> !off_o); // R9
  AST_LOW_SIDE_CHOP: assert property (@(posedge clk) disable iff (!rst_n)
    (off_o && cfg_q.sr == SR_LOWSIDE) |-> (src_en_o && !snk_en_o)); // R4
  AST_FAST_IN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fast_o |-> off_o); // R5
  AST_RECT_IN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rect_en_o |-> off_o); // R6
  AST_ACTIVE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (off_o && cfg_q.sr == SR_ACTIVE && zero_i) |=> !rect_en_o); // R7
  AST_STOP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (off_o && $past(off_o) && $past(rect_en_o) && !rect_en_o) |=> !rect_en_o); // R7
  AST_PASSIVE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (off_o && cfg_q.sr == SR_PASSIVE && rev_lim_i) |=> !rect_en_o); // R8
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dis_w |-> !(src_en_o || snk_en_o || rect_en_o || fast_o || off_o)); // R10
  AST_CFG_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uvlo_i || sleep_i) |-> (cfg_q == '0)); // R11
endmodule

bind offtime_chopper chop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .chop_i(chop_i), .zero_i(zero_i),
  .rev_lim_i(rev_lim_i), .uvlo_i(uvlo_i), .sleep_i(sleep_i), .src_en_o(src_en_o),
  .snk_en_o(snk_en_o), .rect_en_o(rect_en_o), .fast_o(fast_o), .off_o(off_o),
  .dis_w(dis_w), .blank_w(blank_w), .cfg_q(cfg_q)
);

// File: tb/tb_offtime_chopper.sv
`timescale 1ns/1ps
module tb_offtime_chopper;
  localparam int P = 4;
  localparam int BLK = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [11:0] cfg_wd = '0;
  logic trip = 0, chop = 0, zero = 0, rev = 0, fault = 0, uvlo = 0, sleep = 0;
  logic src, snk, rect, fast, offo;

  int checks = 0, fails = 0;
  logic [4:0] qv[$];
  string qt[$];
  int qi[$];

  always #2.5 clk = ~clk;

  offtime_chopper #(.PRESCALE(P), .BLANK_TICKS(BLK), .XOVER_TICKS(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .trip_i(trip), .chop_i(chop), .zero_i(zero), .rev_lim_i(rev),
    .fault_i(fault), .uvlo_i(uvlo), .sleep_i(sleep), .src_en_o(src),
    .snk_en_o(snk), .rect_en_o(rect), .fast_o(fast), .off_o(offo)
  );

  function automatic logic [11:0] mk(int o, int f, int m, int s);
    return {o[4:0], f[3:0], m[0], s[1:0]};
  endfunction

  // Expected {src,snk,rect,fast,off} at phase j of an off period (j<0: conducting)
  function automatic logic [4:0] model(logic [11:0] c, int j, int zat, int rat);
    int o_n, f_n, t_n;
    logic m, ls, r, k;
    o_n = int'(c[11:7]); f_n = int'(c[6:3]); m = c[2];
    t_n = (o_n + 1) * P;
    if (j < 0 || j >= t_n) return 5'b11000;
    ls = (c[1:0] == 2'd3);
    k = (c[1:0] == 2'd1 && zat >= 0 && j > zat) || (c[1:0] == 2'd2 && rat >= 0 && j > rat);
    r = (c[1:0] != 2'd0) && (j >= 2 * P) && !k;
    return {ls, !ls, r, m && (j < f_n * P), 1'b1};
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {src,snk,rect,fast,off} got %b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per clock and compares
  always @(negedge clk) begin
    if (qv.size() > 0) begin
      logic [4:0] e;
      string t;
      int i;
      e = qv.pop_front(); t = qt.pop_front(); i = qi.pop_front();
      checks++;
      if ({src, snk, rect, fast, offo} !== e) begin
        fails++;
        $display("FAIL %s: sample %0d {src,snk,rect,fast,off} got %b expected %b",
                 t, i, {src, snk, rect, fast, offo}, e);
      end
    end
  end

  task automatic write_cfg(logic [11:0] c);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = c;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (200) @(negedge clk);
  endtask

  // Driver: mode 0 single trip, 1 held trip, 2 held chop, 3 single chop
  task automatic run_win(logic [11:0] c, int mode, int zat, int rat, string tag);
    int t_n, s2, len;
    t_n = (int'(c[11:7]) + 1) * P;
    s2 = t_n + 1 + ((mode == 1) ? BLK * P : 0);
    len = (mode == 1 || mode == 2) ? s2 + 8 : t_n + 6;
    @(negedge clk);
    if (mode == 2 || mode == 3) chop = 1'b1; else trip = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < len; i++) begin
      int j;
      if (mode == 0 || mode == 3) j = i;
      else j = (i < t_n) ? i : ((i >= s2) ? i - s2 : -1);
      qv.push_back(model(c, j, zat, rat)); qt.push_back(tag); qi.push_back(i);
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (mode == 0 || mode == 3) begin trip = 1'b0; chop = 1'b0; end
      zero = (i == zat);
      rev = (i == rat);
    end
    @(negedge clk); trip = 0; chop = 0; zero = 0; rev = 0;
    wait (qv.size() == 0);
    settle();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset state", {src, snk, rect, fast, offo}, 5'b11000);

    // R2 R4 R5 R6 R12: mixed decay, active mode, fast shorter than off
    write_cfg(mk(5, 2, 1, 1));
    run_win(mk(5, 2, 1, 1), 0, -1, -1, "R2/R5/R6/R12 mixed active");
    // R5: fast field longer than off time, passive mode
    write_cfg(mk(3, 9, 1, 2));
    run_win(mk(3, 9, 1, 2), 0, -1, -1, "R5 fast exceeds off");
    // R5: slow-only ignores fast field
    write_cfg(mk(4, 3, 0, 1));
    run_win(mk(4, 3, 0, 1), 0, -1, -1, "R5 slow only");
    // R7 R8: active stops on zero flag, ignores reverse flag
    write_cfg(mk(5, 0, 0, 1));
    run_win(mk(5, 0, 0, 1), 0, 10, 9, "R7/R8 active stop");
    // R7 R8: passive ignores zero flag, stops on reverse flag
    write_cfg(mk(5, 0, 0, 2));
    run_win(mk(5, 0, 0, 2), 0, 9, 11, "R7/R8 passive stop");
    // R4 R6: low-side mode chops the sink side
    write_cfg(mk(4, 1, 1, 3));
    run_win(mk(4, 1, 1, 3), 0, -1, -1, "R4/R6 low-side");
    // R6: disabled rectification
    write_cfg(mk(4, 0, 0, 0));
    run_win(mk(4, 0, 0, 0), 0, -1, -1, "R6 rect disabled");
    // R2 R9: held trip restarts only after blanking
    write_cfg(mk(2, 1, 1, 1));
    run_win(mk(2, 1, 1, 1), 1, -1, -1, "R2/R9 held trip blanking");
    // R3: held chop restarts without blanking; single chop
    run_win(mk(2, 1, 1, 1), 2, -1, -1, "R3 held chop");
    run_win(mk(2, 1, 1, 1), 3, -1, -1, "R3 single chop");

    // R10: fault mid-period, configuration kept
    write_cfg(mk(3, 2, 1, 2));
    @(negedge clk); trip = 1'b1;
    @(negedge clk); trip = 1'b0;
    repeat (9) @(negedge clk);
    fault = 1'b1; #1;
    chk("R10 fault outputs low", {src, snk, rect, fast, offo}, 5'b00000);
    repeat (3) @(negedge clk);
    #1 chk("R10 fault held", {src, snk, rect, fast, offo}, 5'b00000);
    fault = 1'b0; #1;
    chk("R10 fault released", {src, snk, rect, fast, offo}, 5'b11000);
    settle();
    run_win(mk(3, 2, 1, 2), 0, -1, -1, "R10 cfg kept after fault");

    // R11: undervoltage wipes configuration and blocks writes
    write_cfg(mk(6, 3, 1, 1));
    @(negedge clk); uvlo = 1'b1; #1;
    chk("R11 uvlo outputs low", {src, snk, rect, fast, offo}, 5'b00000);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = mk(7, 2, 1, 3);
    @(negedge clk); cfg_we = 1'b0; uvlo = 1'b0;
    settle();
    run_win(12'd0, 0, -1, -1, "R11 cfg cleared by uvlo");

    // R11: sleep wipes configuration
    write_cfg(mk(6, 3, 1, 3));
    @(negedge clk); sleep = 1'b1; #1;
    chk("R11 sleep outputs low", {src, snk, rect, fast, offo}, 5'b00000);
    @(negedge clk); sleep = 1'b0;
    settle();
    run_win(12'd0, 0, -1, -1, "R11 cfg cleared by sleep");

    finish_up();
  end
endmodule